// File: doc/BRIEF.md
# Accumulator Instruction-Cycle Processor

This block is a small stored-program processor built around a single 16-bit accumulator. Each instruction word has a 4-bit operation field in bits 15:12 and a 12-bit direct operand address in bits 11:0. The core steps through an explicit fetch sequence: the program counter goes to the memory address register, a read is issued, the returned word is captured in the memory buffer register, and that word is then moved into the instruction register. The execute phase then performs a load, a store or a sign-magnitude add against the addressed word.

The core talks to one synchronous memory port. It has a 12-bit address, separate read and write strobes, and 16-bit write and read data. A read returns data one cycle after the strobe. After reset the core sits halted. A pulse on `run` loads the program counter from `reset_vector` and starts execution. Any operation code other than load, store or add sets a sticky illegal flag and stops the core, and `halted` goes high again. Software normally places such a word at the end of a program as its terminator.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and right after it, `halted` is 1, `mem_rd` and `mem_wr` are 0, and `illegal` and `overflow` are 0.
- R2: Every instruction is read from the address held in the program counter. The first fetch after a start reads `reset_vector`, and each later fetch reads the previous fetch address plus 1, so reads follow program order interleaved with operand reads.
- R3: Operation code 4'b0001 copies the addressed word unchanged into the accumulator, negative zero (16'h8000) included.
- R4: Operation code 4'b0010 writes the accumulator to the operand address with exactly one `mem_wr` cycle and no operand read.
- R5: Operation code 4'b0101 adds the addressed word to the accumulator in sign-magnitude form, with bit 15 as the sign and bits 14:0 as the magnitude. Equal signs add magnitudes and keep the sign. Unequal signs subtract the smaller magnitude from the larger and take the larger operand's sign. A zero magnitude always gets sign 0.
- R6: If an add carries out of the 15-bit magnitude, the magnitude wraps and `overflow` is set. `overflow` then stays set through later instructions until the next start.
- R7: Any operation code other than 4'b0001, 4'b0010 or 4'b0101 sets `illegal` and halts the core, with no further memory access until the next start.
- R8: A read returns its data one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together, and the cycle after a read strobe carries no strobe.
- R9: A `run` pulse while halted restarts the core: it reloads the program counter from `reset_vector` and clears the accumulator, `illegal` and `overflow`. A `run` pulse while the core is executing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start request, sampled while halted |
| reset_vector | input | 12 | Address of the first instruction on start |
| mem_addr | output | 12 | Memory address |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| halted | output | 1 | Core idle or stopped |
| illegal | output | 1 | Sticky illegal-opcode flag |
| overflow | output | 1 | Sticky magnitude-overflow flag |

## Verification
The add path is driven with one fixed program (load, add, store, terminator), and the two operand words change from row to row of a table. The rows cover equal positive signs, equal negative signs, mixed signs where each side is the larger, an exact cancellation, negative zero, and carries out of the magnitude. Together they separate the subtract-and-choose-sign path from the plain add, and show whether zero is normalised and whether overflow is cleared on restart. Separate programs check that a load keeps negative zero, that overflow stays set after a later clean add, that an illegal word stops all memory traffic, and that the address trace follows program order from a relocated start vector. A further run injects a stray `run` pulse mid-program to confirm that it changes nothing.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = WORD_W - ADDR_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_F_MAR,
        ST_F_REQ,
        ST_F_WAIT,
        ST_F_IR,
        ST_X_DEC,
        ST_X_REQ,
        ST_X_WAIT,
        ST_X_DO,
        ST_HALT
    } cpu_state_e;

    typedef struct packed {
        cpu_state_e          state;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   mar;
        logic [WORD_W-1:0]   mbr;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   ac;
        logic                ovf;
        logic                ill;
    } cpu_regs_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             is_load,
    output logic             is_store,
    output logic             is_add,
    output logic             is_illegal
);

    always_comb begin
        is_load    = 1'b0;
        is_store   = 1'b0;
        is_add     = 1'b0;
        is_illegal = 1'b0;
        unique case (opcode)
            OPC_LOAD:  is_load    = 1'b1;
            OPC_STORE: is_store   = 1'b1;
            OPC_ADD:   is_add     = 1'b1;
            default:   is_illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf
);

    localparam int M = W - 1;

    logic         sa, sb, s_res;
    logic [M-1:0] ma, mb, m_res;
    logic [M:0]   wide;

    always_comb begin
        sa    = a[W-1];
        sb    = b[W-1];
        ma    = a[M-1:0];
        mb    = b[M-1:0];
        wide  = '0;
        ovf   = 1'b0;
        s_res = sa;
        if (sa == sb) begin
            wide  = {1'b0, ma} + {1'b0, mb};
            m_res = wide[M-1:0];
            ovf   = wide[M];
        end else if (ma >= mb) begin
            m_res = ma - mb;
            s_res = sa;
        end else begin
            m_res = mb - ma;
            s_res = sb;
        end
        if (m_res == '0) begin
            s_res = 1'b0;
        end
        sum = {s_res, m_res};
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] reset_vector,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted,
    output logic              illegal,
    output logic              overflow
);

    cpu_regs_t r_q, r_d;

    logic              dec_load, dec_store, dec_add, dec_ill;
    logic [WORD_W-1:0] add_sum;
    logic              add_ovf;

    acc_cpu_decode u_dec (
        .opcode     (r_q.ir[WORD_W-1:ADDR_W]),
        .is_load    (dec_load),
        .is_store   (dec_store),
        .is_add     (dec_add),
        .is_illegal (dec_ill)
    );

    acc_cpu_smadd #(.W(WORD_W)) u_add (
        .a   (r_q.ac),
        .b   (r_q.mbr),
        .sum (add_sum),
        .ovf (add_ovf)
    );

    // next-state computation
    always_comb begin
        r_d       = r_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = r_q.mar;
        mem_wdata = r_q.mbr;
        unique case (r_q.state)
            ST_IDLE, ST_HALT: begin
                if (run) begin
                    r_d.pc    = reset_vector;
                    r_d.ac    = '0;
                    r_d.ovf   = 1'b0;
                    r_d.ill   = 1'b0;
                    r_d.state = ST_F_MAR;
                end
            end
            ST_F_MAR: begin
                r_d.mar   = r_q.pc;
                r_d.state = ST_F_REQ;
            end
            ST_F_REQ: begin
                mem_rd    = 1'b1;
                r_d.state = ST_F_WAIT;
            end
            ST_F_WAIT: begin
                r_d.mbr   = mem_rdata;
                r_d.state = ST_F_IR;
            end
            ST_F_IR: begin
                r_d.ir    = r_q.mbr;
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = ST_X_DEC;
            end
            ST_X_DEC: begin
                if (dec_ill) begin
                    r_d.ill   = 1'b1;
                    r_d.state = ST_HALT;
                end else begin
                    r_d.mar = r_q.ir[ADDR_W-1:0];
                    if (dec_store) begin
                        r_d.mbr = r_q.ac;
                    end
                    r_d.state = ST_X_REQ;
                end
            end
            ST_X_REQ: begin
                if (dec_store) begin
                    mem_wr    = 1'b1;
                    r_d.state = ST_F_MAR;
                end else begin
                    mem_rd    = 1'b1;
                    r_d.state = ST_X_WAIT;
                end
            end
            ST_X_WAIT: begin
                r_d.mbr   = mem_rdata;
                r_d.state = ST_X_DO;
            end
            ST_X_DO: begin
                if (dec_load) begin
                    r_d.ac = r_q.mbr;
                end else if (dec_add) begin
                    r_d.ac  = add_sum;
                    r_d.ovf = r_q.ovf | add_ovf;
                end
                r_d.state = ST_F_MAR;
            end
            default: r_d.state = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign halted   = (r_q.state == ST_IDLE) || (r_q.state == ST_HALT);
    assign illegal  = r_q.ill;
    assign overflow = r_q.ovf;

    a_r8_excl_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r8_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    a_r7_quiet_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    a_r7_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ill) |-> (r_q.state == ST_HALT));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_F_IR) |=> (r_q.pc == ADDR_W'($past(r_q.pc) + 1'b1)));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !halted) |=> r_q.ovf);

    a_r9_start_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && run) |=> (r_q.pc == $past(reset_vector) && !r_q.ill && !r_q.ovf));

    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && r_q.state != ST_F_IR) |=> (r_q.pc == $past(r_q.pc)));

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 8;

    // {operand at 0x940, operand at 0x941, expected sum, expected overflow}
    localparam logic [48:0] VEC [NVEC] = '{
        {16'h0003, 16'h0002, 16'h0005, 1'b0},
        {16'h8003, 16'h0002, 16'h8001, 1'b0},
        {16'h0003, 16'h8005, 16'h8002, 1'b0},
        {16'h8004, 16'h8004, 16'h8008, 1'b0},
        {16'h7FFF, 16'h0001, 16'h0000, 1'b1},
        {16'h0005, 16'h8005, 16'h0000, 1'b0},
        {16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1},
        {16'h8000, 16'h0000, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [11:0] reset_vector = 12'h300;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        halted, illegal, overflow;

    logic [15:0] mem [1024];
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        log_clr = 1'b0;
    logic [11:0] rd_log [16];
    int          rd_cnt = 0;
    int          wr_cnt = 0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .reset_vector (reset_vector),
        .mem_addr     (mem_addr),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .halted       (halted),
        .illegal      (illegal),
        .overflow     (overflow)
    );

    // memory model with one-cycle read latency and an address trace
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr[9:0]] <= ld_data;
        if (mem_wr) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[9:0]];
            if (rd_cnt < 16) rd_log[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (log_clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            errors = errors + 1;
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // start the core, optionally inject a stray run pulse, wait for halt
    task automatic go(input bit stray);
        int n;
        @(negedge clk);
        run = 1'b1; log_clr = 1'b1;
        @(negedge clk);
        run = 1'b0; log_clr = 1'b0;
        if (stray) begin
            repeat (3) @(negedge clk);
            run = 1'b1;
            @(negedge clk);
            run = 1'b0;
        end
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R7 halt reached", 32'(halted), 32'd1);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 halted in reset", 32'(halted), 32'd1);
        check("R1 rd low in reset", 32'(mem_rd), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 halted after reset", 32'(halted), 32'd1);
        check("R1 no strobes", 32'({mem_rd, mem_wr}), 32'd0);
        check("R1 flags clear", 32'({illegal, overflow}), 32'd0);

        // standard add program at 0x300, terminator opcode 0
        poke(12'h300, 16'h1940);
        poke(12'h301, 16'h5941);
        poke(12'h302, 16'h2941);
        poke(12'h303, 16'h0000);

        // table walk: R5 sign-magnitude add, R6 overflow cleared on restart
        for (int i = 0; i < NVEC; i++) begin
            poke(12'h940, VEC[i][48:33]);
            poke(12'h941, VEC[i][32:17]);
            go(1'b0);
            check($sformatf("R5 sum row %0d", i), 32'(mem[12'h141]), 32'(VEC[i][16:1]));
            check($sformatf("R6 overflow row %0d", i), 32'(overflow), 32'(VEC[i][0]));
            check($sformatf("R7 terminator row %0d", i), 32'(illegal), 32'd1);
        end

        // R2/R4/R8 trace, R9 stray run ignored mid-program
        poke(12'h940, 16'h0003);
        poke(12'h941, 16'h0002);
        go(1'b1);
        check("R9 stray run ignored, result", 32'(mem[12'h141]), 32'h0005);
        check("R2 read count", 32'(rd_cnt), 32'd6);
        check("R4 one write", 32'(wr_cnt), 32'd1);
        check("R2 read 0", 32'(rd_log[0]), 32'h300);
        check("R8 operand read 1", 32'(rd_log[1]), 32'h940);
        check("R2 read 2", 32'(rd_log[2]), 32'h301);
        check("R8 operand read 3", 32'(rd_log[3]), 32'h941);
        check("R2 read 4", 32'(rd_log[4]), 32'h302);
        check("R2 read 5", 32'(rd_log[5]), 32'h303);

        // R6 overflow sticks across a later clean add
        poke(12'h940, 16'h7FFF);
        poke(12'h941, 16'h0001);
        poke(12'h942, 16'h0003);
        poke(12'h302, 16'h5942);
        poke(12'h303, 16'h2943);
        poke(12'h304, 16'h0000);
        go(1'b0);
        check("R6 wrapped then added", 32'(mem[12'h143]), 32'h0003);
        check("R6 overflow sticky", 32'(overflow), 32'd1);

        // R3 load keeps negative zero and arbitrary words; new reset vector
        reset_vector = 12'h040;
        poke(12'h944, 16'h8000);
        poke(12'h946, 16'h8ABC);
        poke(12'h040, 16'h1944);
        poke(12'h041, 16'h2945);
        poke(12'h042, 16'h1946);
        poke(12'h043, 16'h2947);
        poke(12'h044, 16'hF000);
        go(1'b0);
        check("R3 load negative zero", 32'(mem[12'h145]), 32'h8000);
        check("R3 load word", 32'(mem[12'h147]), 32'h8ABC);
        check("R2 start at vector", 32'(rd_log[0]), 32'h040);
        check("R9 overflow cleared on start", 32'(overflow), 32'd0);

        // R7 illegal first word: one fetch, then silence
        reset_vector = 12'h020;
        poke(12'h020, 16'h7123);
        go(1'b0);
        repeat (10) @(negedge clk);
        check("R7 illegal flag", 32'(illegal), 32'd1);
        check("R7 single fetch only", 32'(rd_cnt), 32'd1);
        check("R7 no write", 32'(wr_cnt), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule